// File: doc/BRIEF.md
# Serial ATA Link Receive Responder

This block sits between the physical layer and the transport layer on the receive side of a serial ATA style link. Every clock cycle it takes one 32-bit dword plus a flag saying whether that dword is a control primitive or data. In the same cycle it chooses the primitive to send back to the far end. Before any decoding, the block expands continuation-compressed runs. A continuation primitive turns the dwords that follow it into copies of the last real primitive, until a new primitive arrives.

Between a start-of-frame primitive and a wait-for-termination primitive, the block collects data dwords. It removes the scrambling from each one as it arrives and feeds a running CRC. Because the final dword of a frame is the CRC itself, every payload dword is held back by one data dword. The held word is handed to the transport side only once a later data dword proves it is not the last one. When the frame closes, the block compares the held last word against the running CRC. It then gives a one-cycle frame strobe together with a pass/fail flag.

A back-pressure input makes the block answer with a hold primitive instead of the in-progress primitive while a frame is being received. All primitive codes are parameters of the top module.

Top module: `sata_rx_responder`

## Requirements
- R1: After a continuation primitive (code `CODE_CONT`, flagged as primitive), that dword and every following dword are decoded as the last recorded non-continuation primitive, until a primitive other than `CODE_CONT` arrives. Such substituted dwords are never appended to a frame. After reset the recorded primitive is `CODE_SYNC`.
- R2: A primitive other than `CODE_CONT` is decoded as itself, becomes the recorded primitive, and ends continuation mode.
- R3: A decoded `CODE_XRDY` makes `tx_prim` equal `CODE_RRDY` on the next clock. This holds whether or not a frame is open.
- R4: A decoded `CODE_SOF` while no frame is open does three things. It opens a frame and makes `tx_prim` equal `CODE_RIP` on the next clock. It also seeds the descrambler with 0xFFFF and the CRC with `CRC_SEED`. A `CODE_SOF` while a frame is open is treated like any other in-frame primitive.
- R5: While a frame is open, a decoded dword that is neither `CODE_XRDY`, `CODE_WTRM`, `CODE_HOLD` nor `CODE_EOF` sets `tx_prim` on the next clock. It becomes `CODE_HOLD` if `force_hold` was 1 in that cycle, and `CODE_RIP` otherwise. Data dwords among them are appended to the frame.
- R6: A decoded `CODE_HOLD` makes `tx_prim` equal `CODE_HOLDA` on the next clock. A decoded `CODE_EOF` leaves `tx_prim` unchanged.
- R7: A decoded `CODE_WTRM` makes `tx_prim` equal `CODE_ROK` on the next clock. If a frame was open, `frame_done` is 1 for exactly that next cycle and the frame closes. Otherwise `frame_done` stays 0.
- R8: Descrambling XORs the n-th appended data dword (n from 0) with the n-th word of a 16-bit LFSR sequence. Bit i of a word, i = 0 to 31, is state bit 15. After each bit the state shifts left by one, and the new bit 0 is the XOR of bits 15, 14, 12 and 3 (x^16+x^15+x^13+x^4+1).
- R9: Every descrambled dword of a frame except the last appears on `pl_data` with `pl_valid` = 1 for one cycle. This happens on the clock after the next data dword of that frame is received. The last dword is never emitted, and `pl_valid` and `frame_done` are never 1 together.
- R10: The CRC is computed MSB first over the emitted dwords, with polynomial 0x04C11DB7, seed `CRC_SEED` (0x52325032), and no reflection or final inversion. `crc_ok` is 1 alongside `frame_done` when the last descrambled dword equals that CRC. A frame with no data dwords gives 0. `crc_ok` holds its value until the next `frame_done`.
- R11: While no frame is open, any other decoded dword sets `tx_prim` to `CODE_SYNC` on the next clock. After reset `tx_prim` is `CODE_SYNC` and `pl_valid`, `frame_done` and `crc_ok` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one dword per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dword | input | 32 | Dword received from the physical layer |
| rx_is_prim | input | 1 | 1 when `rx_dword` is a primitive, 0 for data |
| force_hold | input | 1 | Back-pressure: reply hold instead of in-progress inside a frame |
| tx_prim | output | 32 | Primitive to send back, registered |
| pl_data | output | 32 | Descrambled payload dword |
| pl_valid | output | 1 | `pl_data` is valid this cycle |
| frame_done | output | 1 | One-cycle strobe at frame close |
| crc_ok | output | 1 | CRC result of the last closed frame |

## Verification
Every result is registered once after the decoding logic. The reply to a dword, the frame strobe with its CRC flag, and the release of a payload word therefore all appear one clock after the dword that causes them. The exception is that a payload word waits for the next data dword, not for its own arrival. The bench drives each dword half a cycle before the edge and steps a behavioural model of the protocol on that edge. It then compares every output against the model just after the edge. The model keeps received dwords in a queue and works out the CRC only at close, so the one-dword hold-back is predicted from the queue, not copied from the design.

// File: rtl/sata_rx_pkg.sv
package sata_rx_pkg;

  localparam int unsigned DWORD_W = 32;
  localparam int unsigned LFSR_W  = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hD008; // bits 15,14,12,3
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hFFFF;

  typedef logic [DWORD_W-1:0] dword_t;
  typedef logic [LFSR_W-1:0]  lfsr_t;

  // Scrambler word produced from state s: bit i is the state's top bit
  // before the i-th shift.
  function automatic dword_t scr_word(lfsr_t s);
    dword_t w;
    lfsr_t  st;
    st = s;
    for (int i = 0; i < DWORD_W; i++) begin
      w[i] = st[LFSR_W-1];
      st   = {st[LFSR_W-2:0], ^(st & LFSR_TAPS)};
    end
    return w;
  endfunction

  // State after one full word of shifts.
  function automatic lfsr_t scr_next(lfsr_t s);
    lfsr_t st;
    st = s;
    for (int i = 0; i < DWORD_W; i++) begin
      st = {st[LFSR_W-2:0], ^(st & LFSR_TAPS)};
    end
    return st;
  endfunction

  // MSB-first CRC update, one data bit at a time.
  function automatic dword_t crc_fold(dword_t crc, dword_t d, dword_t poly);
    dword_t c;
    logic   fb;
    c = crc;
    for (int i = DWORD_W-1; i >= 0; i--) begin
      fb = c[DWORD_W-1] ^ d[i];
      c  = {c[DWORD_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/sata_cont_expander.sv
module sata_cont_expander
  import sata_rx_pkg::*;
#(
  parameter dword_t CODE_CONT = 32'h9999AA7C,
  parameter dword_t CODE_INIT = 32'hB5B5957C
) (
  input  logic   clk,
  input  logic   rst_n,
  input  dword_t in_word,
  input  logic   in_prim,
  output dword_t eff_word,
  output logic   eff_prim
);

  logic   cont_q;
  dword_t last_q;
  logic   is_cont;

  assign is_cont = in_prim && (in_word == CODE_CONT);

  always_comb begin
    if (in_prim && !is_cont) begin
      eff_word = in_word;
      eff_prim = 1'b1;
    end else if (is_cont || cont_q) begin
      eff_word = last_q;
      eff_prim = 1'b1;
    end else begin
      eff_word = in_word;
      eff_prim = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cont_q <= 1'b0;
      last_q <= CODE_INIT;
    end else if (is_cont) begin
      cont_q <= 1'b1;
    end else if (in_prim) begin
      cont_q <= 1'b0;
      last_q <= in_word;
    end
  end

endmodule

// File: rtl/sata_reply_picker.sv
module sata_reply_picker
  import sata_rx_pkg::*;
#(
  parameter dword_t CODE_SYNC  = 32'hB5B5957C,
  parameter dword_t CODE_XRDY  = 32'h5757B57C,
  parameter dword_t CODE_SOF   = 32'h3737B57C,
  parameter dword_t CODE_EOF   = 32'hD5D5B57C,
  parameter dword_t CODE_HOLD  = 32'hD5D5AA7C,
  parameter dword_t CODE_HOLDA = 32'h9595AA7C,
  parameter dword_t CODE_WTRM  = 32'h5858B57C,
  parameter dword_t CODE_RRDY  = 32'h4A4A957C,
  parameter dword_t CODE_RIP   = 32'h5555B57C,
  parameter dword_t CODE_ROK   = 32'h3535B57C
) (
  input  logic   clk,
  input  logic   rst_n,
  input  dword_t eff_word,
  input  logic   eff_prim,
  input  logic   force_hold,
  output dword_t reply,
  output logic   frame_open,
  output logic   ev_open,
  output logic   ev_data,
  output logic   ev_close
);

  dword_t nxt_reply;
  logic   nxt_open;
  logic   hit_xrdy, hit_wtrm, hit_hold, hit_eof, hit_sof;

  assign hit_xrdy = eff_prim && (eff_word == CODE_XRDY);
  assign hit_wtrm = eff_prim && (eff_word == CODE_WTRM);
  assign hit_hold = eff_prim && (eff_word == CODE_HOLD);
  assign hit_eof  = eff_prim && (eff_word == CODE_EOF);
  assign hit_sof  = eff_prim && (eff_word == CODE_SOF);

  // Priority follows the decode order: ready, terminate, hold, end,
  // then in-frame traffic, then frame start, else idle.
  always_comb begin
    nxt_reply = reply;
    nxt_open  = frame_open;
    ev_open   = 1'b0;
    ev_data   = 1'b0;
    ev_close  = 1'b0;
    if (hit_xrdy) begin
      nxt_reply = CODE_RRDY;
    end else if (hit_wtrm) begin
      nxt_reply = CODE_ROK;
      if (frame_open) begin
        ev_close = 1'b1;
        nxt_open = 1'b0;
      end
    end else if (hit_hold) begin
      nxt_reply = CODE_HOLDA;
    end else if (hit_eof) begin
      nxt_reply = reply;
    end else if (frame_open) begin
      nxt_reply = force_hold ? CODE_HOLD : CODE_RIP;
      ev_data   = !eff_prim;
    end else if (hit_sof) begin
      nxt_reply = CODE_RIP;
      nxt_open  = 1'b1;
      ev_open   = 1'b1;
    end else begin
      nxt_reply = CODE_SYNC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reply      <= CODE_SYNC;
      frame_open <= 1'b0;
    end else begin
      reply      <= nxt_reply;
      frame_open <= nxt_open;
    end
  end

endmodule

// File: rtl/sata_frame_checker.sv
module sata_frame_checker
  import sata_rx_pkg::*;
#(
  parameter dword_t CRC_POLY = 32'h04C11DB7,
  parameter dword_t CRC_SEED = 32'h52325032
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_open,
  input  logic   ev_data,
  input  logic   ev_close,
  input  dword_t data_in,
  output dword_t pl_data,
  output logic   pl_valid,
  output logic   frame_done,
  output logic   crc_ok,
  output logic   crc_match
);

  lfsr_t  scr_q;
  dword_t crc_q;
  dword_t held_q;
  logic   held_v;
  dword_t clear_word;

  assign clear_word = data_in ^ scr_word(scr_q);
  assign crc_match  = held_v && (held_q == crc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr_q      <= LFSR_SEED;
      crc_q      <= CRC_SEED;
      held_q     <= '0;
      held_v     <= 1'b0;
      pl_data    <= '0;
      pl_valid   <= 1'b0;
      frame_done <= 1'b0;
      crc_ok     <= 1'b0;
    end else begin
      pl_valid   <= 1'b0;
      frame_done <= 1'b0;
      if (ev_open) begin
        scr_q  <= LFSR_SEED;
        crc_q  <= CRC_SEED;
        held_v <= 1'b0;
      end else if (ev_data) begin
        held_q <= clear_word;
        held_v <= 1'b1;
        scr_q  <= scr_next(scr_q);
        if (held_v) begin
          pl_valid <= 1'b1;
          pl_data  <= held_q;
          crc_q    <= crc_fold(crc_q, held_q, CRC_POLY);
        end
      end else if (ev_close) begin
        frame_done <= 1'b1;
        crc_ok     <= crc_match;
        held_v     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sata_rx_responder.sv
module sata_rx_responder
  import sata_rx_pkg::*;
#(
  parameter logic [31:0] CODE_SYNC  = 32'hB5B5957C,
  parameter logic [31:0] CODE_CONT  = 32'h9999AA7C,
  parameter logic [31:0] CODE_XRDY  = 32'h5757B57C,
  parameter logic [31:0] CODE_SOF   = 32'h3737B57C,
  parameter logic [31:0] CODE_EOF   = 32'hD5D5B57C,
  parameter logic [31:0] CODE_HOLD  = 32'hD5D5AA7C,
  parameter logic [31:0] CODE_HOLDA = 32'h9595AA7C,
  parameter logic [31:0] CODE_WTRM  = 32'h5858B57C,
  parameter logic [31:0] CODE_RRDY  = 32'h4A4A957C,
  parameter logic [31:0] CODE_RIP   = 32'h5555B57C,
  parameter logic [31:0] CODE_ROK   = 32'h3535B57C,
  parameter logic [31:0] CRC_POLY   = 32'h04C11DB7,
  parameter logic [31:0] CRC_SEED   = 32'h52325032
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] rx_dword,
  input  logic        rx_is_prim,
  input  logic        force_hold,
  output logic [31:0] tx_prim,
  output logic [31:0] pl_data,
  output logic        pl_valid,
  output logic        frame_done,
  output logic        crc_ok
);

  // Named internal events, visible to the bound checker.
  dword_t eff_word;
  logic   eff_prim;
  logic   frame_open;
  logic   ev_open;
  logic   ev_data;
  logic   ev_close;
  logic   crc_match;

  sata_cont_expander #(
    .CODE_CONT (CODE_CONT),
    .CODE_INIT (CODE_SYNC)
  ) u_expand (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_word  (rx_dword),
    .in_prim  (rx_is_prim),
    .eff_word (eff_word),
    .eff_prim (eff_prim)
  );

  sata_reply_picker #(
    .CODE_SYNC  (CODE_SYNC),
    .CODE_XRDY  (CODE_XRDY),
    .CODE_SOF   (CODE_SOF),
    .CODE_EOF   (CODE_EOF),
    .CODE_HOLD  (CODE_HOLD),
    .CODE_HOLDA (CODE_HOLDA),
    .CODE_WTRM  (CODE_WTRM),
    .CODE_RRDY  (CODE_RRDY),
    .CODE_RIP   (CODE_RIP),
    .CODE_ROK   (CODE_ROK)
  ) u_reply (
    .clk        (clk),
    .rst_n      (rst_n),
    .eff_word   (eff_word),
    .eff_prim   (eff_prim),
    .force_hold (force_hold),
    .reply      (tx_prim),
    .frame_open (frame_open),
    .ev_open    (ev_open),
    .ev_data    (ev_data),
    .ev_close   (ev_close)
  );

  sata_frame_checker #(
    .CRC_POLY (CRC_POLY),
    .CRC_SEED (CRC_SEED)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_open    (ev_open),
    .ev_data    (ev_data),
    .ev_close   (ev_close),
    .data_in    (eff_word),
    .pl_data    (pl_data),
    .pl_valid   (pl_valid),
    .frame_done (frame_done),
    .crc_ok     (crc_ok),
    .crc_match  (crc_match)
  );

endmodule

// File: rtl/sata_rx_responder_chk.sv
module sata_rx_responder_chk #(
  parameter logic [31:0] CODE_CONT  = 32'h9999AA7C,
  parameter logic [31:0] CODE_XRDY  = 32'h5757B57C,
  parameter logic [31:0] CODE_HOLD  = 32'hD5D5AA7C,
  parameter logic [31:0] CODE_HOLDA = 32'h9595AA7C,
  parameter logic [31:0] CODE_WTRM  = 32'h5858B57C,
  parameter logic [31:0] CODE_RRDY  = 32'h4A4A957C,
  parameter logic [31:0] CODE_RIP   = 32'h5555B57C,
  parameter logic [31:0] CODE_ROK   = 32'h3535B57C
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] rx_dword,
  input logic        rx_is_prim,
  input logic        force_hold,
  input logic [31:0] eff_word,
  input logic        eff_prim,
  input logic [31:0] tx_prim,
  input logic        frame_open,
  input logic        ev_data,
  input logic        ev_close,
  input logic        crc_match,
  input logic        pl_valid,
  input logic        frame_done,
  input logic        crc_ok
);

  assert_cont_repeat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_is_prim && rx_dword == CODE_CONT) |=>
      ((rx_is_prim && rx_dword != CODE_CONT) ||
       (eff_prim && eff_word == $past(eff_word))));

  assert_prim_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_is_prim && rx_dword != CODE_CONT) |-> (eff_prim && eff_word == rx_dword));

  assert_ready_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_prim && eff_word == CODE_XRDY) |=> (tx_prim == CODE_RRDY));

  assert_inframe_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_open && !eff_prim) |=>
      (tx_prim == ($past(force_hold) ? CODE_HOLD : CODE_RIP)));

  assert_hold_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_prim && eff_word == CODE_HOLD) |=> (tx_prim == CODE_HOLDA));

  assert_close_reply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_prim && eff_word == CODE_WTRM) |=> (tx_prim == CODE_ROK && !frame_open));

  assert_close_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_close |=> frame_done);

  assert_strobe_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(ev_close));

  assert_payload_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |-> $past(ev_data));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pl_valid && frame_done));

  assert_crc_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_close |=> (crc_ok == $past(crc_match)));

endmodule

bind sata_rx_responder sata_rx_responder_chk #(
  .CODE_CONT  (CODE_CONT),
  .CODE_XRDY  (CODE_XRDY),
  .CODE_HOLD  (CODE_HOLD),
  .CODE_HOLDA (CODE_HOLDA),
  .CODE_WTRM  (CODE_WTRM),
  .CODE_RRDY  (CODE_RRDY),
  .CODE_RIP   (CODE_RIP),
  .CODE_ROK   (CODE_ROK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_dword   (rx_dword),
  .rx_is_prim (rx_is_prim),
  .force_hold (force_hold),
  .eff_word   (eff_word),
  .eff_prim   (eff_prim),
  .tx_prim    (tx_prim),
  .frame_open (frame_open),
  .ev_data    (ev_data),
  .ev_close   (ev_close),
  .crc_match  (crc_match),
  .pl_valid   (pl_valid),
  .frame_done (frame_done),
  .crc_ok     (crc_ok)
);

// File: tb/sata_rx_responder_test.sv
module sata_rx_responder_test;

  localparam logic [31:0] K_SYNC  = 32'hB5B5957C;
  localparam logic [31:0] K_CONT  = 32'h9999AA7C;
  localparam logic [31:0] K_XRDY  = 32'h5757B57C;
  localparam logic [31:0] K_SOF   = 32'h3737B57C;
  localparam logic [31:0] K_EOF   = 32'hD5D5B57C;
  localparam logic [31:0] K_HOLD  = 32'hD5D5AA7C;
  localparam logic [31:0] K_HOLDA = 32'h9595AA7C;
  localparam logic [31:0] K_WTRM  = 32'h5858B57C;
  localparam logic [31:0] K_RRDY  = 32'h4A4A957C;
  localparam logic [31:0] K_RIP   = 32'h5555B57C;
  localparam logic [31:0] K_ROK   = 32'h3535B57C;
  localparam logic [31:0] POLY    = 32'h04C11DB7;
  localparam logic [31:0] SEED    = 32'h52325032;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rx_dword = '0;
  logic        rx_is_prim = 1'b0;
  logic        force_hold = 1'b0;
  logic [31:0] tx_prim;
  logic [31:0] pl_data;
  logic        pl_valid;
  logic        frame_done;
  logic        crc_ok;

  always #5 clk = ~clk;

  sata_rx_responder uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_dword   (rx_dword),
    .rx_is_prim (rx_is_prim),
    .force_hold (force_hold),
    .tx_prim    (tx_prim),
    .pl_data    (pl_data),
    .pl_valid   (pl_valid),
    .frame_done (frame_done),
    .crc_ok     (crc_ok)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // ---------------- behavioural model ----------------
  bit          m_cont;
  logic [31:0] m_last;
  bit          m_open;
  int          m_lfsr;
  logic [31:0] m_q[$];
  logic [31:0] e_reply;
  bit          e_plv;
  logic [31:0] e_pld;
  bit          e_done;
  bit          e_ok;
  int          emitted;

  function automatic logic [31:0] tb_scr(inout int s);
    logic [31:0] w;
    int fb;
    for (int k = 0; k < 32; k++) begin
      w[k] = s[15];
      fb = ((s >> 15) ^ (s >> 14) ^ (s >> 12) ^ (s >> 3)) & 1;
      s = ((s << 1) | fb) & 32'hFFFF;
    end
    return w;
  endfunction

  function automatic logic [31:0] tb_crc(logic [31:0] c, logic [31:0] d);
    logic [31:0] r;
    r = c ^ d;
    for (int k = 0; k < 32; k++) r = r[31] ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  task automatic model_reset();
    m_cont = 0; m_last = K_SYNC; m_open = 0; m_lfsr = 32'hFFFF;
    m_q.delete();
    e_reply = K_SYNC; e_plv = 0; e_pld = '0; e_done = 0; e_ok = 0;
  endtask

  task automatic model_step(logic [31:0] w, bit p, bit fh);
    logic [31:0] ew;
    bit ep;
    logic [31:0] c;
    if (p && w == K_CONT) begin m_cont = 1; ew = m_last; ep = 1; end
    else if (p) begin m_last = w; m_cont = 0; ew = w; ep = 1; end
    else if (m_cont) begin ew = m_last; ep = 1; end
    else begin ew = w; ep = 0; end
    e_plv = 0; e_done = 0;
    if (ep && ew == K_XRDY) e_reply = K_RRDY;
    else if (ep && ew == K_WTRM) begin
      e_reply = K_ROK;
      if (m_open) begin
        e_done = 1; m_open = 0;
        if (m_q.size() == 0) e_ok = 0;
        else begin
          c = SEED;
          for (int k = 0; k < m_q.size() - 1; k++) c = tb_crc(c, m_q[k]);
          e_ok = (c == m_q[m_q.size()-1]);
        end
        m_q.delete();
      end
    end
    else if (ep && ew == K_HOLD) e_reply = K_HOLDA;
    else if (ep && ew == K_EOF) e_reply = e_reply;
    else if (m_open) begin
      e_reply = fh ? K_HOLD : K_RIP;
      if (!ep) begin
        if (m_q.size() > 0) begin e_plv = 1; e_pld = m_q[m_q.size()-1]; end
        m_q.push_back(ew ^ tb_scr(m_lfsr));
      end
    end
    else if (ep && ew == K_SOF) begin
      e_reply = K_RIP; m_open = 1; m_lfsr = 32'hFFFF; m_q.delete();
    end
    else e_reply = K_SYNC;
  endtask

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One dword per cycle; compared against the model just after the edge.
  task automatic send(logic [31:0] w, bit p, bit fh, string tag);
    @(negedge clk);
    rx_dword = w; rx_is_prim = p; force_hold = fh;
    @(posedge clk);
    #1;
    model_step(w, p, fh);
    check(tx_prim == e_reply, tag, "tx_prim", tx_prim, e_reply);
    check(pl_valid == e_plv, tag, "pl_valid", {31'd0, pl_valid}, {31'd0, e_plv});
    if (e_plv) check(pl_data == e_pld, tag, "pl_data", pl_data, e_pld);
    if (pl_valid) emitted++;
    check(frame_done == e_done, tag, "frame_done", {31'd0, frame_done}, {31'd0, e_done});
    check(crc_ok == e_ok, tag, "crc_ok", {31'd0, crc_ok}, {31'd0, e_ok});
  endtask

  // Build a frame from plain payload words: append CRC, scramble, send.
  logic [31:0] plain[$];
  task automatic send_frame(bit corrupt, bit want_ok, string tag);
    logic [31:0] c;
    int s;
    int n;
    c = SEED;
    foreach (plain[k]) c = tb_crc(c, plain[k]);
    if (corrupt) c = c ^ 32'h0000_0100;
    n = plain.size();
    s = 32'hFFFF;
    emitted = 0;
    send(K_SOF, 1, 0, "R4");
    for (int k = 0; k < n; k++) send(plain[k] ^ tb_scr(s), 0, 0, tag);
    send(c ^ tb_scr(s), 0, 0, tag);
    send(K_EOF, 1, 0, "R6");
    send(K_WTRM, 1, 0, "R7");
    check(frame_done == 1'b1, "R7", "frame strobe", {31'd0, frame_done}, 32'd1);
    check(crc_ok == want_ok, "R10", "crc verdict", {31'd0, crc_ok}, {31'd0, want_ok});
    check(emitted == n, "R9", "payload count", emitted, n);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    check(tx_prim == K_SYNC, "R11", "reset tx_prim", tx_prim, K_SYNC);
    check(!pl_valid && !frame_done && !crc_ok, "R11", "reset flags",
          {29'd0, pl_valid, frame_done, crc_ok}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    send(K_SYNC, 1, 0, "R11");
    send(32'h1234_5678, 0, 0, "R11");
    send(K_XRDY, 1, 0, "R3");

    // Good frame, several payload words (R8 descramble, R9 release, R10 CRC)
    plain = {32'h0000_0001, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'h0A0B_0C0D};
    send_frame(0, 1, "R8");

    // Corrupted CRC
    plain = {32'h1111_2222, 32'h3333_4444, 32'h5555_6666};
    send_frame(1, 0, "R10");

    // CRC-only frame: empty payload, CRC word equals the seed
    plain = {};
    send_frame(0, 1, "R10");

    // Frame with hold, continuation, back-pressure and a stray start
    begin
      int s;
      logic [31:0] c;
      plain = {32'hCAFE_0001, 32'hCAFE_0002, 32'hCAFE_0003};
      c = SEED;
      foreach (plain[k]) c = tb_crc(c, plain[k]);
      s = 32'hFFFF;
      emitted = 0;
      send(K_XRDY, 1, 0, "R3");
      send(K_SOF, 1, 0, "R4");
      send(plain[0] ^ tb_scr(s), 0, 0, "R8");
      send(K_HOLD, 1, 0, "R6");
      send(K_CONT, 1, 0, "R1");
      send(32'h7777_7777, 0, 0, "R1");
      send(32'h8888_8888, 0, 1, "R1");
      check(tx_prim == K_HOLDA, "R1", "continued hold ack", tx_prim, K_HOLDA);
      send(K_SYNC, 1, 0, "R2");
      check(tx_prim == K_RIP, "R2", "cont ended reply", tx_prim, K_RIP);
      send(plain[1] ^ tb_scr(s), 0, 1, "R5");
      check(tx_prim == K_HOLD, "R5", "back-pressure reply", tx_prim, K_HOLD);
      send(K_SOF, 1, 0, "R4");
      send(plain[2] ^ tb_scr(s), 0, 0, "R9");
      send(c ^ tb_scr(s), 0, 0, "R10");
      send(K_WTRM, 1, 0, "R7");
      check(crc_ok == 1'b1, "R1", "cont data not appended", {31'd0, crc_ok}, 32'd1);
      check(emitted == 3, "R9", "payload count", emitted, 3);
    end

    // Empty frame: no data at all
    send(K_SOF, 1, 0, "R4");
    send(K_WTRM, 1, 0, "R10");
    check(frame_done && !crc_ok, "R10", "empty frame verdict",
          {30'd0, frame_done, crc_ok}, 32'd2);

    // Terminate while idle: reply but no strobe; end leaves reply as is
    send(K_WTRM, 1, 0, "R7");
    check(frame_done == 1'b0, "R7", "idle terminate strobe", {31'd0, frame_done}, 32'd0);
    send(K_EOF, 1, 0, "R6");
    check(tx_prim == K_ROK, "R6", "end keeps reply", tx_prim, K_ROK);

    // Continuation while idle repeats ready
    send(K_XRDY, 1, 0, "R1");
    send(K_CONT, 1, 0, "R1");
    send(32'h0000_0000, 0, 0, "R1");
    send(32'h3737B57C, 0, 0, "R1");
    check(tx_prim == K_RRDY, "R1", "repeat ready", tx_prim, K_RRDY);
    send(K_SYNC, 1, 0, "R2");
    send(32'h3737B57C, 0, 0, "R2");
    check(tx_prim == K_SYNC, "R2", "data after cont end", tx_prim, K_SYNC);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule